// File: doc/BRIEF.md
# Triple-Lane Majority-Voted Pipeline

This block carries a 26-bit word (one sign bit and 25 magnitude bits, treated as raw bits by the stage arithmetic) through seven register stages. Each stage is built three times as identical lanes. After every stage a bitwise two-of-three voter merges the three lane results. The merged word, together with its valid bit, then feeds the next stage of all three lanes. A wrong value in one lane is therefore corrected at the boundary where it appears. It cannot spread forward. A different lane may be wrong at each of the seven stages and the final word is still correct.

Each stage applies a fixed, parameterised transform so that the end-to-end result can be predicted. Even-numbered stages add a constant. Odd-numbered stages rotate the word left. For test, one lane's output at one stage can be corrupted by XOR with a mask before the vote. Each stage raises a disagreement flag while any lane differs from the vote. These flags collect in a sticky register that a synchronous clear input empties.

Top module: `tmr_voted_pipe`

## Requirements
- R1: While reset is asserted and before the first clock edge after its release, out_valid is 0, out_data is 0, fault_sticky is 0 and stage_mismatch is 0.
- R2: in_valid sampled at a clock edge appears on out_valid after the sixth following edge, which is seven register stages in total.
- R3: out_data is the input word passed through stages 0 to 6 in order. Stage k with k even (0, 2, 4, 6) adds (ADD_BASE + k) modulo 2^26, with ADD_BASE defaulting to 437. Stage k with k odd (1, 3, 5) rotates the 26-bit word left by ROT_AMT bits, which defaults to 3.
- R4: A corruption injected into any single lane at any single stage never changes out_data or out_valid.
- R5: When inj_en is 1, inj_lane is 0, 1 or 2, inj_stage is below 7 and inj_mask is nonzero, stage_mismatch equals one-hot bit inj_stage in that same cycle. When the mask is zero, stage_mismatch is 0.
- R6: A stage_mismatch bit present at a clock edge without fault_clr sets the matching fault_sticky bit after that edge. Set bits stay set until cleared.
- R7: fault_clr high at a clock edge makes fault_sticky all zero after that edge, even when a mismatch is present in the same cycle.
- R8: An injection with inj_lane equal to 3, or with inj_stage equal to 7, has no effect: stage_mismatch stays 0 and the output is unchanged.
- R9: With inj_en low, inj_lane, inj_stage and inj_mask have no effect, and stage_mismatch is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word strobe |
| in_data | input | 26 | Input word |
| inj_en | input | 1 | Enable fault injection this cycle |
| inj_lane | input | 2 | Lane to corrupt (0 to 2) |
| inj_stage | input | 3 | Stage to corrupt (0 to 6) |
| inj_mask | input | 26 | Bits XORed into the chosen lane-stage output |
| fault_clr | input | 1 | Synchronous clear of fault_sticky |
| out_valid | output | 1 | Voted valid after the last stage |
| out_data | output | 26 | Voted word after the last stage |
| stage_mismatch | output | 7 | Per-stage lane disagreement, combinational |
| fault_sticky | output | 7 | Accumulated stage_mismatch bits |

## Verification
The assertions assume that the injection port holds at most one fault per cycle, which a single lane/stage selector enforces at the interface. They also assume that all three lanes start from the same reset state, so any disagreement can only come from the port. Under these conditions the flag vector is zero or one-hot, and it points at the selected stage whenever the mask is nonzero. The random stimulus uses lane 3 and stage 7 and an occasional zero mask to reach the ignored-injection cases. It raises fault_clr rarely and at random, sometimes in the same cycle as a live injection, so that the clear-priority rule is exercised as well.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   localparam int TMR_LANES = 3;

   typedef enum logic {
      XF_ADD = 1'b0,
      XF_ROT = 1'b1
   } xform_kind_e;

   function automatic xform_kind_e stage_kind(input int stage);
      return (stage % 2 == 0) ? XF_ADD : XF_ROT;
   endfunction

endpackage

// File: rtl/tmr_maj_voter.sv
module tmr_maj_voter #(
   parameter int W = 27
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [W-1:0] c,
   output logic [W-1:0] y,
   output logic         split
);

   if (W < 1) begin : g_bad_w
      $error("tmr_maj_voter: W must be positive");
   end

   always_comb begin
      y     = (a & b) | (a & c) | (b & c);
      split = |((a ^ y) | (b ^ y) | (c ^ y));
   end

endmodule

// File: rtl/tmr_stage_xform.sv
module tmr_stage_xform
   import tmr_pkg::*;
#(
   parameter int W        = 26,
   parameter int STAGE    = 0,
   parameter int ADD_BASE = 437,
   parameter int ROT_AMT  = 3
) (
   input  logic [W-1:0] x,
   output logic [W-1:0] y
);

   localparam xform_kind_e KIND = stage_kind(STAGE);
   localparam logic [W-1:0] ADD_K = W'(ADD_BASE + STAGE);

   if (KIND == XF_ADD) begin : g_add
      assign y = x + ADD_K;
   end else begin : g_rot
      if (ROT_AMT < 1 || ROT_AMT >= W) begin : g_bad_rot
         $error("tmr_stage_xform: ROT_AMT must lie in 1..W-1");
      end
      assign y = {x[W-1-ROT_AMT:0], x[W-1:W-ROT_AMT]};
   end

endmodule

// File: rtl/tmr_lane_stage.sv
module tmr_lane_stage #(
   parameter int W        = 26,
   parameter int STAGE    = 0,
   parameter int ADD_BASE = 437,
   parameter int ROT_AMT  = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W:0]   vin,
   input  logic         inj_hit,
   input  logic [W-1:0] inj_mask,
   output logic [W:0]   vout
);

   logic [W-1:0] xf_y;
   logic [W:0]   q;

   tmr_stage_xform #(
      .W       (W),
      .STAGE   (STAGE),
      .ADD_BASE(ADD_BASE),
      .ROT_AMT (ROT_AMT)
   ) u_xf (
      .x(vin[W-1:0]),
      .y(xf_y)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= {vin[W], xf_y};
   end

   assign vout = q ^ {1'b0, (inj_hit ? inj_mask : {W{1'b0}})};

endmodule

// File: rtl/tmr_voted_pipe.sv
module tmr_voted_pipe
   import tmr_pkg::*;
#(
   parameter int DATA_W   = 26,
   parameter int N_STAGES = 7,
   parameter int STG_W    = (N_STAGES > 1) ? $clog2(N_STAGES + 1) : 1,
   parameter int ADD_BASE = 437,
   parameter int ROT_AMT  = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [DATA_W-1:0]   in_data,
   input  logic                inj_en,
   input  logic [1:0]          inj_lane,
   input  logic [STG_W-1:0]    inj_stage,
   input  logic [DATA_W-1:0]   inj_mask,
   input  logic                fault_clr,
   output logic                out_valid,
   output logic [DATA_W-1:0]   out_data,
   output logic [N_STAGES-1:0] stage_mismatch,
   output logic [N_STAGES-1:0] fault_sticky
);

   localparam int WV = DATA_W + 1;

   if (DATA_W < 2) begin : g_bad_dw
      $error("tmr_voted_pipe: DATA_W must be at least 2");
   end
   if (N_STAGES < 1) begin : g_bad_ns
      $error("tmr_voted_pipe: N_STAGES must be at least 1");
   end
   if ((1 << STG_W) <= N_STAGES) begin : g_bad_sw
      $error("tmr_voted_pipe: STG_W too narrow to encode an unused stage");
   end
   if (TMR_LANES != 3) begin : g_bad_lanes
      $error("tmr_voted_pipe: voter needs exactly three lanes");
   end

   logic [WV-1:0] vote_bus [N_STAGES+1];
   logic [WV-1:0] lane_out [TMR_LANES][N_STAGES];

   assign vote_bus[0] = {in_valid, in_data};

   for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
      for (genvar l = 0; l < TMR_LANES; l++) begin : g_lane
         logic hit;
         assign hit = inj_en
                   && (inj_lane == 2'(l))
                   && (inj_stage == STG_W'(s));

         tmr_lane_stage #(
            .W       (DATA_W),
            .STAGE   (s),
            .ADD_BASE(ADD_BASE),
            .ROT_AMT (ROT_AMT)
         ) u_ls (
            .clk     (clk),
            .rst_n   (rst_n),
            .vin     (vote_bus[s]),
            .inj_hit (hit),
            .inj_mask(inj_mask),
            .vout    (lane_out[l][s])
         );
      end

      tmr_maj_voter #(.W(WV)) u_vote (
         .a    (lane_out[0][s]),
         .b    (lane_out[1][s]),
         .c    (lane_out[2][s]),
         .y    (vote_bus[s+1]),
         .split(stage_mismatch[s])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         fault_sticky <= '0;
      else if (fault_clr) fault_sticky <= '0;
      else                fault_sticky <= fault_sticky | stage_mismatch;
   end

   assign out_valid = vote_bus[N_STAGES][DATA_W];
   assign out_data  = vote_bus[N_STAGES][DATA_W-1:0];

endmodule

// File: rtl/tmr_voted_pipe_chk.sv
module tmr_voted_pipe_chk #(
   parameter int DATA_W   = 26,
   parameter int N_STAGES = 7,
   parameter int STG_W    = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic                in_valid,
   input logic                inj_en,
   input logic [1:0]          inj_lane,
   input logic [STG_W-1:0]    inj_stage,
   input logic [DATA_W-1:0]   inj_mask,
   input logic                fault_clr,
   input logic                out_valid,
   input logic [N_STAGES-1:0] stage_mismatch,
   input logic [N_STAGES-1:0] fault_sticky
);

   logic [N_STAGES-1:0] vshift;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vshift <= '0;
      else        vshift <= {vshift[N_STAGES-2:0], in_valid};
   end

   logic live_inj;
   assign live_inj = inj_en && (inj_lane != 2'd3)
                  && (int'(inj_stage) < N_STAGES);

   p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |-> (out_valid == vshift[N_STAGES-1]));

   p_single_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |-> $onehot0(stage_mismatch));

   p_flag_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (live_inj && inj_mask != '0) |->
         (stage_mismatch == (N_STAGES'(1) << inj_stage)));

   p_sticky_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !fault_clr |=> ((fault_sticky & $past(fault_sticky | stage_mismatch))
                      == $past(fault_sticky | stage_mismatch)));

   p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fault_clr |=> (fault_sticky == '0));

   p_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (inj_en && !live_inj) |-> (stage_mismatch == '0));

   p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !inj_en |-> (stage_mismatch == '0));

endmodule

bind tmr_voted_pipe tmr_voted_pipe_chk #(
   .DATA_W  (DATA_W),
   .N_STAGES(N_STAGES),
   .STG_W   (STG_W)
) u_chk (.*);

// File: tb/tmr_voted_pipe_test.sv
module tmr_voted_pipe_test;

   localparam int DW  = 26;
   localparam int NS  = 7;
   localparam int SW  = 3;
   localparam int ADB = 437;
   localparam int ROT = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic          inj_en = 1'b0;
   logic [1:0]    inj_lane = '0;
   logic [SW-1:0] inj_stage = '0;
   logic [DW-1:0] inj_mask = '0;
   logic          fault_clr = 1'b0;
   logic          out_valid;
   logic [DW-1:0] out_data;
   logic [NS-1:0] stage_mismatch;
   logic [NS-1:0] fault_sticky;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   logic          hist_v [8];
   logic [DW-1:0] hist_d [8];
   logic [NS-1:0] exp_sticky = '0;
   int            cyc = 0;

   always #5 clk = ~clk;

   tmr_voted_pipe #(
      .DATA_W  (DW),
      .N_STAGES(NS),
      .STG_W   (SW),
      .ADD_BASE(ADB),
      .ROT_AMT (ROT)
   ) uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .in_valid      (in_valid),
      .in_data       (in_data),
      .inj_en        (inj_en),
      .inj_lane      (inj_lane),
      .inj_stage     (inj_stage),
      .inj_mask      (inj_mask),
      .fault_clr     (fault_clr),
      .out_valid     (out_valid),
      .out_data      (out_data),
      .stage_mismatch(stage_mismatch),
      .fault_sticky  (fault_sticky)
   );

   function automatic logic [DW-1:0] ref_pipe(input logic [DW-1:0] d);
      logic [DW-1:0] x = d;
      for (int k = 0; k < NS; k++) begin
         if (k % 2 == 0) x = x + DW'(ADB + k);
         else            x = (x << ROT) | (x >> (DW - ROT));
      end
      return x;
   endfunction

   function automatic logic [NS-1:0] ref_flag(input logic en, input logic [1:0] ln,
                                              input logic [SW-1:0] st,
                                              input logic [DW-1:0] m);
      if (en && ln != 2'd3 && int'(st) < NS && m != '0)
         return NS'(1) << st;
      return '0;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic cycle(input logic v, input logic [DW-1:0] d, input logic en,
                        input logic [1:0] ln, input logic [SW-1:0] st,
                        input logic [DW-1:0] m, input logic clr);
      logic [NS-1:0] ef;
      string tag;
      in_valid = v; in_data = d; inj_en = en; inj_lane = ln;
      inj_stage = st; inj_mask = m; fault_clr = clr;
      #1;
      ef = ref_flag(en, ln, st, m);
      if (!en)        tag = "R9 flag";
      else if (ef != 0) tag = "R5 flag";
      else if (ln == 2'd3 || int'(st) >= NS) tag = "R8 flag";
      else            tag = "R5 zero-mask flag";
      chk(stage_mismatch == ef, tag, 64'(stage_mismatch), 64'(ef));
      hist_v[cyc % 8] = v;
      hist_d[cyc % 8] = ref_pipe(d);
      exp_sticky = clr ? '0 : (exp_sticky | ef);
      @(negedge clk);
      chk(fault_sticky == exp_sticky, clr ? "R7 sticky clear" : "R6 sticky",
          64'(fault_sticky), 64'(exp_sticky));
      if (cyc >= NS - 1) begin
         chk(out_valid == hist_v[(cyc - (NS - 1)) % 8], "R2 valid latency",
             64'(out_valid), 64'(hist_v[(cyc - (NS - 1)) % 8]));
         chk(out_data == hist_d[(cyc - (NS - 1)) % 8], "R3 R4 voted data",
             64'(out_data), 64'(hist_d[(cyc - (NS - 1)) % 8]));
      end else begin
         chk(out_valid == 1'b0, "R2 valid before fill", 64'(out_valid), 64'(0));
      end
      cyc++;
   endtask

   initial begin
      #(200000 * 10);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R1 valid in reset", 64'(out_valid), 64'(0));
      chk(fault_sticky == '0, "R1 sticky in reset", 64'(fault_sticky), 64'(0));
      rst_n = 1'b1;
      #1;
      chk(out_data == '0, "R1 data after reset", 64'(out_data), 64'(0));
      chk(stage_mismatch == '0, "R1 flags after reset", 64'(stage_mismatch), 64'(0));

      // R3 directed: no faults, distinct patterns
      cycle(1'b1, '0, 1'b0, 2'd0, '0, '0, 1'b0);
      cycle(1'b1, {DW{1'b1}}, 1'b0, 2'd0, '0, '0, 1'b0);
      cycle(1'b1, DW'(1) << (DW - 1), 1'b0, 2'd0, '0, '0, 1'b0);
      cycle(1'b0, DW'(26'h2AAAAAA), 1'b0, 2'd0, '0, '0, 1'b0);

      // R4/R5: each lane at each stage with full mask
      for (int s = 0; s < NS; s++) begin
         for (int l = 0; l < 3; l++) begin
            cycle(1'b1, DW'($urandom), 1'b1, 2'(l), SW'(s), {DW{1'b1}}, 1'b0);
         end
      end
      // R8: unused lane and unused stage
      cycle(1'b1, DW'($urandom), 1'b1, 2'd3, SW'(2), {DW{1'b1}}, 1'b0);
      cycle(1'b1, DW'($urandom), 1'b1, 2'd1, SW'(7), {DW{1'b1}}, 1'b0);
      // R7: clear wins over a live mismatch
      cycle(1'b1, DW'($urandom), 1'b1, 2'd2, SW'(4), DW'(1), 1'b1);
      // R6: flag then hold
      cycle(1'b0, DW'($urandom), 1'b1, 2'd0, SW'(6), DW'(5), 1'b0);
      cycle(1'b0, DW'($urandom), 1'b0, 2'd0, '0, '0, 1'b0);

      // Constrained random phase
      for (int i = 0; i < 3000; i++) begin
         logic [DW-1:0] m;
         case ($urandom % 8)
            0:       m = '0;
            1:       m = {DW{1'b1}};
            default: m = DW'($urandom);
         endcase
         cycle(($urandom % 4) != 0, DW'($urandom), ($urandom % 2) == 1,
               2'($urandom % 4), SW'($urandom % 8), m, ($urandom % 16) == 0);
      end
      repeat (NS + 1) cycle(1'b0, '0, 1'b0, 2'd0, '0, '0, 1'b0);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule